// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. It fetches from a separate instruction memory and reads and writes a separate data memory. Both memories sit outside the block: the core presents an instruction address and receives the instruction word in the same cycle, and it presents a data address with the store data and a write strobe, receiving the load data combinationally. The program counter, the 32-entry register file and the data memory write all take effect on the same rising edge.

A purely combinational decoder turns the opcode, the function field and a "source register is zero" flag into the datapath controls. Those controls cover a four-way next-PC choice (sequential, PC-relative branch, register target, absolute target), a three-way write-back choice (ALU result, load data, return address) and a three-way destination choice (rt, rd, register 31). The instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], 16-bit immediate [15:0] and 26-bit jump target [25:0].

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, imem_addr is 0 and dmem_we is 0; after reset every register reads 0 and the first instruction fetched is at address 0.
- R2: Opcode 0x00 with function 0x20 ADD, 0x22 SUB, 0x24 AND, 0x25 OR, 0x26 XOR, 0x2A signed set-less-than, 0x2B unsigned set-less-than writes rd with the result of rs (op) rt.
- R3: Immediate ops write rt with rs (op) ext(imm): 0x08 add, 0x0A signed less-than and 0x0B unsigned less-than use the sign-extended immediate; 0x0C AND, 0x0D OR, 0x0E XOR use the zero-extended immediate; 0x0F writes the immediate into bits 31:16 with the low half zero.
- R4: Load (opcode 0x23) reads the data word at rs plus the sign-extended immediate and writes it to rt.
- R5: Store (opcode 0x2B) drives dmem_we high for that cycle with dmem_addr equal to rs plus the sign-extended immediate and dmem_wdata equal to rt; no other instruction raises dmem_we.
- R6: Branch-if-zero (0x04) is taken when rs is 0 and branch-if-nonzero (0x05) when rs is not 0; a taken branch goes to PC+4 plus the sign-extended immediate times 4, otherwise to PC+4.
- R7: Jump (0x02) and jump-and-link (0x03) go to {PC[31:28], target, 2'b00}; jump-and-link also writes PC+4 to register 31.
- R8: Register jump (0x16) and register jump-and-link (0x17) go to the value of rs read before the instruction's own write; the linking form writes PC+4 to register 31.
- R9: Register 0 always reads as 0; writes whose destination is register 0 are dropped.
- R10: An unsupported opcode, or opcode 0x00 with an unlisted function, writes no register and no memory and advances the PC by 4.
- R11: Every non-control instruction advances the PC by 4, and a register or memory written by one instruction is seen by the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for the data access (ALU result) |
| dmem_wdata | output | 32 | Store data (value of rt) |
| dmem_we | output | 1 | Data memory write strobe, taken on the rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, valid in the same cycle |

## Verification
The bench steers a program through the cases that are easy to get subtly wrong: a register jump-and-link whose source is register 31 itself (a core that wrote the link before reading rs would jump to its own return address), a load right after a store to the same word (a core with the write placed on the wrong edge would return stale data), and a backward branch with a negative offset (an unsigned or unshifted offset would leave the loop at the wrong address). It also writes register 0 by both an immediate and a register op, executes an all-ones opcode and an unlisted function code, and stores every result, so a core that failed to drop those writes or mixed up zero and sign extension would put a wrong word on dmem_wdata. The PC is compared with the reference model on every clock, which catches any wrong branch direction or target in the cycle it happens.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
// Package: shared control encodings, opcode and function codes for the
// single-cycle core. Assumes a 32-bit instruction word with a 6-bit opcode.
package sc_core_pkg;

    localparam int XLEN     = 32;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int REG_AW   = 5;
    localparam logic [REG_AW-1:0] LINK_REG = 5'd31;

    // opcodes
    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_JUMP    = 6'h02;
    localparam logic [5:0] OP_JLINK   = 6'h03;
    localparam logic [5:0] OP_BRZ     = 6'h04;
    localparam logic [5:0] OP_BRNZ    = 6'h05;
    localparam logic [5:0] OP_ADDI    = 6'h08;
    localparam logic [5:0] OP_SLTI    = 6'h0A;
    localparam logic [5:0] OP_SLTIU   = 6'h0B;
    localparam logic [5:0] OP_ANDI    = 6'h0C;
    localparam logic [5:0] OP_ORI     = 6'h0D;
    localparam logic [5:0] OP_XORI    = 6'h0E;
    localparam logic [5:0] OP_HIIMM   = 6'h0F;
    localparam logic [5:0] OP_RJUMP   = 6'h16;
    localparam logic [5:0] OP_RJLINK  = 6'h17;
    localparam logic [5:0] OP_LOAD    = 6'h23;
    localparam logic [5:0] OP_STORE   = 6'h2B;

    // function codes under OP_SPECIAL
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [1:0] {NPC_SEQ, NPC_BRANCH, NPC_REG, NPC_ABS} npc_sel_e;
    typedef enum logic [1:0] {WB_ALU, WB_LOAD, WB_RET} wb_sel_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;
    typedef enum logic [1:0] {IMX_SIGN, IMX_ZERO, IMX_HIGH} imx_sel_e;
    typedef enum logic [2:0] {
        AOP_ADD, AOP_SUB, AOP_AND, AOP_OR, AOP_XOR, AOP_SLT, AOP_SLTU, AOP_PASSB
    } alu_op_e;

    typedef struct packed {
        npc_sel_e npc_sel;
        wb_sel_e  wb_sel;
        dst_sel_e dst_sel;
        imx_sel_e imx_sel;
        alu_op_e  alu_op;
        logic     b_is_imm;
        logic     reg_we;
        logic     mem_we;
    } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// Register file: NREGS x W, two combinational read ports, one write port
// taken on the rising edge. Entry 0 is a constant zero, so writes to it
// are dropped. All other entries clear on synchronous active-low reset.
module sc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREGS)-1:0] ra1,
    input  logic [$clog2(NREGS)-1:0] ra2,
    output logic [W-1:0]             rd1,
    output logic [W-1:0]             rd2,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [W-1:0]             wd
);
    localparam int AW = $clog2(NREGS);

    logic [W-1:0] regs [NREGS];

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            if (g == 0) begin : g_zero
                assign regs[g] = '0;
            end else begin : g_store
                logic [W-1:0] q;
                // holds entry g; loads wd when this entry is addressed
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        q <= '0;
                    end else if (we && wa == AW'(g)) begin
                        q <= wd;
                    end
                end
                assign regs[g] = q;
            end
        end
    endgenerate

    // combinational read ports
    always_comb begin
        rd1 = regs[ra1];
        rd2 = regs[ra2];
    end

endmodule

// File: rtl/sc_decoder.sv
`timescale 1ns/1ps
// Decoder: one combinational map from opcode, function field and the
// "rs equals zero" flag to every datapath control. Anything not listed
// decodes to a sequential no-op with no register or memory write.
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] func,
    input  logic       rs_zero,
    output ctrl_t      ctrl
);
    // per-opcode control selection
    always_comb begin
        ctrl.npc_sel  = NPC_SEQ;
        ctrl.wb_sel   = WB_ALU;
        ctrl.dst_sel  = DST_RT;
        ctrl.imx_sel  = IMX_SIGN;
        ctrl.alu_op   = AOP_ADD;
        ctrl.b_is_imm = 1'b0;
        ctrl.reg_we   = 1'b0;
        ctrl.mem_we   = 1'b0;
        unique case (opcode)
            OP_SPECIAL: begin
                ctrl.dst_sel = DST_RD;
                ctrl.reg_we  = 1'b1;
                unique case (func)
                    FN_ADD:  ctrl.alu_op = AOP_ADD;
                    FN_SUB:  ctrl.alu_op = AOP_SUB;
                    FN_AND:  ctrl.alu_op = AOP_AND;
                    FN_OR:   ctrl.alu_op = AOP_OR;
                    FN_XOR:  ctrl.alu_op = AOP_XOR;
                    FN_SLT:  ctrl.alu_op = AOP_SLT;
                    FN_SLTU: ctrl.alu_op = AOP_SLTU;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OP_ADDI, OP_SLTI, OP_SLTIU: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.alu_op   = (opcode == OP_ADDI) ? AOP_ADD :
                                (opcode == OP_SLTI) ? AOP_SLT : AOP_SLTU;
            end
            OP_ANDI, OP_ORI, OP_XORI: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.imx_sel  = IMX_ZERO;
                ctrl.alu_op   = (opcode == OP_ANDI) ? AOP_AND :
                                (opcode == OP_ORI)  ? AOP_OR  : AOP_XOR;
            end
            OP_HIIMM: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.imx_sel  = IMX_HIGH;
                ctrl.alu_op   = AOP_PASSB;
            end
            OP_LOAD: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.wb_sel   = WB_LOAD;
            end
            OP_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OP_BRZ:  ctrl.npc_sel = rs_zero  ? NPC_BRANCH : NPC_SEQ;
            OP_BRNZ: ctrl.npc_sel = !rs_zero ? NPC_BRANCH : NPC_SEQ;
            OP_JUMP: ctrl.npc_sel = NPC_ABS;
            OP_JLINK: begin
                ctrl.npc_sel = NPC_ABS;
                ctrl.reg_we  = 1'b1;
                ctrl.dst_sel = DST_LINK;
                ctrl.wb_sel  = WB_RET;
            end
            OP_RJUMP: ctrl.npc_sel = NPC_REG;
            OP_RJLINK: begin
                ctrl.npc_sel = NPC_REG;
                ctrl.reg_we  = 1'b1;
                ctrl.dst_sel = DST_LINK;
                ctrl.wb_sel  = WB_RET;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_exec.sv
`timescale 1ns/1ps
// Execute helpers: immediate extension (sign, zero, upper half) and the
// ALU. Assumes W is at least 17 so the immediate fits below the top bit.
module sc_immext
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [IMM_W-1:0] imm,
    input  imx_sel_e         sel,
    output logic [W-1:0]     val
);
    // chooses one of the three extension forms
    always_comb begin
        unique case (sel)
            IMX_ZERO: val = {{(W-IMM_W){1'b0}}, imm};
            IMX_HIGH: val = {imm, {(W-IMM_W){1'b0}}};
            default:  val = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
        endcase
    end
endmodule

// ALU: two W-bit operands, one result, no flags.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    // result mux over the supported operations
    always_comb begin
        unique case (op)
            AOP_SUB:   y = a - b;
            AOP_AND:   y = a & b;
            AOP_OR:    y = a | b;
            AOP_XOR:   y = a ^ b;
            AOP_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            AOP_SLTU:  y = {{(W-1){1'b0}}, (a < b)};
            AOP_PASSB: y = b;
            default:   y = a + b;
        endcase
    end
endmodule

// File: rtl/sc_nextpc.sv
`timescale 1ns/1ps
// Next-PC unit: sequential, PC-relative branch (word offset), register
// target and absolute target spliced under the current PC's top 4 bits.
// Assumes a 32-bit PC so that 4 + 26 + 2 bits form the absolute target.
module sc_nextpc
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     rs_val,
    input  logic [IMM_W-1:0] offset,
    input  logic [TGT_W-1:0] target,
    input  npc_sel_e         sel,
    output logic [W-1:0]     pc_plus4,
    output logic [W-1:0]     npc
);
    localparam int HI_W = W - TGT_W - 2;

    logic [W-1:0] br_disp;

    // sequential address and scaled branch displacement
    always_comb begin
        pc_plus4 = pc + W'(4);
        br_disp  = {{(W-IMM_W-2){offset[IMM_W-1]}}, offset, 2'b00};
    end

    // next-PC source selection
    always_comb begin
        unique case (sel)
            NPC_BRANCH: npc = pc_plus4 + br_disp;
            NPC_REG:    npc = rs_val;
            NPC_ABS:    npc = {pc[W-1 -: HI_W], target, 2'b00};
            default:    npc = pc_plus4;
        endcase
    end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
// Single-cycle core top: PC register, decoder, register file, execute
// and next-PC logic. Instruction and data memories are external and read
// combinationally; the data write happens on the same edge as the PC and
// register updates. Synchronous active-low reset sets the PC to RESET_PC.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int          NREGS    = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    localparam int W  = XLEN;
    localparam int AW = $clog2(NREGS);

    logic [W-1:0]     pc, pc_next, pc_plus4;
    logic [5:0]       opcode, func;
    logic [AW-1:0]    rs, rt, rd, rf_wa;
    logic [IMM_W-1:0] imm;
    logic [TGT_W-1:0] target;
    logic [W-1:0]     rs_val, rt_val, imm_val, alu_b, alu_y, rf_wd;
    logic             rs_zero, rf_we;
    ctrl_t            ctrl;

    // instruction field split
    always_comb begin
        opcode = imem_rdata[31:26];
        rs     = imem_rdata[25:21];
        rt     = imem_rdata[20:16];
        rd     = imem_rdata[15:11];
        func   = imem_rdata[5:0];
        imm    = imem_rdata[15:0];
        target = imem_rdata[25:0];
    end

    sc_decoder u_dec (
        .opcode  (opcode),
        .func    (func),
        .rs_zero (rs_zero),
        .ctrl    (ctrl)
    );

    sc_regfile #(.NREGS(NREGS), .W(W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs),
        .ra2   (rt),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    sc_immext #(.W(W)) u_imx (
        .imm (imm),
        .sel (ctrl.imx_sel),
        .val (imm_val)
    );

    sc_alu #(.W(W)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    sc_nextpc #(.W(W)) u_npc (
        .pc       (pc),
        .rs_val   (rs_val),
        .offset   (imm),
        .target   (target),
        .sel      (ctrl.npc_sel),
        .pc_plus4 (pc_plus4),
        .npc      (pc_next)
    );

    // operand, destination and write-back selection
    always_comb begin
        rs_zero = (rs_val == '0);
        alu_b   = ctrl.b_is_imm ? imm_val : rt_val;
        rf_we   = ctrl.reg_we;
        unique case (ctrl.dst_sel)
            DST_RD:   rf_wa = rd;
            DST_LINK: rf_wa = LINK_REG;
            default:  rf_wa = rt;
        endcase
        unique case (ctrl.wb_sel)
            WB_LOAD: rf_wd = dmem_rdata;
            WB_RET:  rf_wd = pc_plus4;
            default: rf_wd = alu_y;
        endcase
    end

    // data memory interface; no store while reset is held
    always_comb begin
        dmem_addr  = alu_y;
        dmem_wdata = rt_val;
        dmem_we    = ctrl.mem_we && rst_n;
        imem_addr  = pc;
    end

    // program counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else begin
            pc <= pc_next;
        end
    end

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
// Checker for sc_core: relates the fetched instruction to the PC of the
// following cycle, to the store strobe and to the register write enable.
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic        dmem_we,
    input logic [31:0] rs_val,
    input logic        rf_we
);
    logic [5:0] op;
    logic       legal, ctl_op, br_taken;

    // independent classification of the current instruction
    always_comb begin
        op = imem_rdata[31:26];
        unique case (op)
            OP_SPECIAL: legal = (imem_rdata[5:0] inside
                                 {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLT, FN_SLTU});
            OP_JUMP, OP_JLINK, OP_BRZ, OP_BRNZ, OP_ADDI, OP_SLTI, OP_SLTIU,
            OP_ANDI, OP_ORI, OP_XORI, OP_HIIMM, OP_RJUMP, OP_RJLINK,
            OP_LOAD, OP_STORE: legal = 1'b1;
            default: legal = 1'b0;
        endcase
        ctl_op   = op inside {OP_JUMP, OP_JLINK, OP_BRZ, OP_BRNZ, OP_RJUMP, OP_RJLINK};
        br_taken = (op == OP_BRZ && rs_val == 32'd0) || (op == OP_BRNZ && rs_val != 32'd0);
    end

    // R5: only a store raises the data write strobe
    p_store_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (op == OP_STORE));

    // R9: a zero rs field always reads zero
    p_r0_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[25:21] == 5'd0) |-> (rs_val == 32'd0));

    // R10: unsupported encodings write nothing
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> (!dmem_we && !rf_we));

    // R11: non-control instructions step the PC by 4
    p_seq_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_op |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R6: taken branch target
    p_branch_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (imem_addr == $past(imem_addr) + 32'd4 +
                      {{14{$past(imem_rdata[15])}}, $past(imem_rdata[15:0]), 2'b00}));

    // R7: absolute jump target
    p_abs_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JUMP || op == OP_JLINK) |=>
        (imem_addr == {$past(imem_addr[31:28]), $past(imem_rdata[25:0]), 2'b00}));

    // R8: register jump target
    p_reg_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RJUMP || op == OP_RJLINK) |=> (imem_addr == $past(rs_val)));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .rs_val     (rs_val),
    .rf_we      (rf_we)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
// Bench: program in a behavioural instruction memory, a data memory
// written by the core, and an instruction-level reference model stepped
// once per clock and compared with the core's ports on every cycle.
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] im   [256];
    logic [31:0] dm   [256];
    logic [31:0] m_dm [256];
    logic [31:0] m_rf [32];
    string       m_wtag [32];
    logic [31:0] m_pc;
    string       pc_tag;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = im[imem_addr[9:2]];
    assign dmem_rdata = dm[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) dm[dmem_addr[9:2]] <= dmem_wdata;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rt_w(input int s, input int t, input int d, input logic [5:0] f);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
    endfunction
    function automatic logic [31:0] it_w(input logic [5:0] op, input int s, input int t, input logic [15:0] i);
        return {op, 5'(s), 5'(t), i};
    endfunction
    function automatic logic [31:0] jt_w(input logic [5:0] op, input int tgt);
        return {op, 26'(tgt)};
    endfunction

    // reference model: one instruction per call
    task automatic model_step();
        logic [31:0] ins, a, b, sx, zx, val, npc;
        logic [5:0]  op, fn;
        int          dst;
        bit          wr;
        string       tag;
        ins = im[m_pc[9:2]];
        op  = ins[31:26];
        fn  = ins[5:0];
        a   = m_rf[ins[25:21]];
        b   = m_rf[ins[20:16]];
        sx  = {{16{ins[15]}}, ins[15:0]};
        zx  = {16'h0, ins[15:0]};
        npc = m_pc + 32'd4;
        wr  = 1'b0; dst = int'(ins[20:16]); val = '0; tag = "R3";
        pc_tag = "R11";
        case (op)
            6'h00: begin
                wr = 1'b1; dst = int'(ins[15:11]); tag = "R2";
                case (fn)
                    6'h20: val = a + b;
                    6'h22: val = a - b;
                    6'h24: val = a & b;
                    6'h25: val = a | b;
                    6'h26: val = a ^ b;
                    6'h2A: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    6'h2B: val = (a < b) ? 32'd1 : 32'd0;
                    default: begin wr = 1'b0; pc_tag = "R10"; end
                endcase
            end
            6'h08: begin wr = 1'b1; val = a + sx; end
            6'h0A: begin wr = 1'b1; val = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; end
            6'h0B: begin wr = 1'b1; val = (a < sx) ? 32'd1 : 32'd0; end
            6'h0C: begin wr = 1'b1; val = a & zx; end
            6'h0D: begin wr = 1'b1; val = a | zx; end
            6'h0E: begin wr = 1'b1; val = a ^ zx; end
            6'h0F: begin wr = 1'b1; val = {ins[15:0], 16'h0}; end
            6'h23: begin wr = 1'b1; val = m_dm[8'((a + sx) >> 2)]; tag = "R4"; end
            6'h2B: m_dm[8'((a + sx) >> 2)] = b;
            6'h04: begin pc_tag = "R6"; if (a == 0) npc = m_pc + 32'd4 + (sx << 2); end
            6'h05: begin pc_tag = "R6"; if (a != 0) npc = m_pc + 32'd4 + (sx << 2); end
            6'h02: begin pc_tag = "R7"; npc = {m_pc[31:28], ins[25:0], 2'b00}; end
            6'h03: begin pc_tag = "R7"; npc = {m_pc[31:28], ins[25:0], 2'b00};
                         wr = 1'b1; dst = 31; val = m_pc + 32'd4; tag = "R7"; end
            6'h16: begin pc_tag = "R8"; npc = a; end
            6'h17: begin pc_tag = "R8"; npc = a; wr = 1'b1; dst = 31;
                         val = m_pc + 32'd4; tag = "R8"; end
            default: pc_tag = "R10";
        endcase
        if (wr && dst != 0) begin
            m_rf[dst]   = val;
            m_wtag[dst] = tag;
        end
        m_pc = npc;
    endtask

    // per-cycle comparison of the ports against the model
    task automatic compare_cycle();
        logic [31:0] ins, exp_addr;
        ins = im[m_pc[9:2]];
        check(pc_tag, "pc", imem_addr, m_pc);
        if (ins[31:26] == 6'h2B) begin
            exp_addr = m_rf[ins[25:21]] + {{16{ins[15]}}, ins[15:0]};
            check("R5", "store strobe", {31'd0, dmem_we}, 32'd1);
            check("R5", "store address", dmem_addr, exp_addr);
            check(m_wtag[ins[20:16]], "store data", dmem_wdata, m_rf[ins[20:16]]);
        end else begin
            check(pc_tag == "R10" ? "R10" : "R5", "no store", {31'd0, dmem_we}, 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // program image
    initial begin
        for (int i = 0; i < 256; i++) begin
            im[i] = '0; dm[i] = '0; m_dm[i] = '0;
        end
        for (int i = 0; i < 32; i++) begin
            m_rf[i] = '0;
            m_wtag[i] = (i == 0) ? "R9" : "R1";
        end
        im[0]  = it_w(6'h2B, 0, 25, 16'h0300);
        im[1]  = it_w(6'h0F, 0, 1, 16'h8000);
        im[2]  = it_w(6'h0D, 1, 1, 16'h0005);
        im[3]  = it_w(6'h08, 0, 2, 16'hFFFD);
        im[4]  = it_w(6'h08, 0, 3, 16'h0007);
        im[5]  = rt_w(1, 2, 4, 6'h20);
        im[6]  = rt_w(3, 2, 5, 6'h22);
        im[7]  = rt_w(1, 2, 6, 6'h24);
        im[8]  = rt_w(1, 3, 7, 6'h25);
        im[9]  = rt_w(2, 3, 8, 6'h26);
        im[10] = rt_w(2, 3, 9, 6'h2A);
        im[11] = rt_w(2, 3, 10, 6'h2B);
        im[12] = it_w(6'h0A, 2, 11, 16'hFFFE);
        im[13] = it_w(6'h0B, 3, 12, 16'hFFFF);
        im[14] = it_w(6'h0C, 2, 13, 16'hFFFF);
        im[15] = it_w(6'h0E, 2, 14, 16'h00FF);
        im[16] = it_w(6'h08, 0, 0, 16'h0005);
        im[17] = rt_w(3, 3, 0, 6'h20);
        im[18] = it_w(6'h08, 0, 20, 16'h0100);
        im[19] = it_w(6'h08, 0, 21, 16'h0200);
        for (int j = 0; j < 15; j++) im[20 + j] = it_w(6'h2B, 20, j, 16'(4 * j));
        im[35] = it_w(6'h2B, 21, 3, 16'hFFFC);
        im[36] = it_w(6'h23, 21, 15, 16'hFFFC);
        im[37] = it_w(6'h2B, 20, 15, 16'h0040);
        im[38] = 32'hFFFF_FFFF;
        im[39] = rt_w(3, 3, 16, 6'h3F);
        im[40] = it_w(6'h2B, 20, 16, 16'h0044);
        im[41] = it_w(6'h04, 0, 0, 16'h0001);
        im[42] = it_w(6'h08, 0, 17, 16'h0055);
        im[43] = it_w(6'h05, 0, 0, 16'h0001);
        im[44] = it_w(6'h04, 3, 0, 16'h0001);
        im[45] = it_w(6'h05, 3, 0, 16'h0001);
        im[46] = it_w(6'h08, 17, 17, 16'h0033);
        im[47] = it_w(6'h08, 0, 18, 16'h0003);
        im[48] = it_w(6'h08, 18, 18, 16'hFFFF);
        im[49] = it_w(6'h05, 18, 0, 16'hFFFE);
        im[50] = it_w(6'h2B, 20, 17, 16'h0048);
        im[51] = jt_w(6'h03, 60);
        im[52] = it_w(6'h2B, 20, 31, 16'h004C);
        im[53] = it_w(6'h08, 0, 22, 16'h0100);
        im[54] = it_w(6'h17, 22, 0, 16'h0000);
        im[55] = it_w(6'h2B, 20, 31, 16'h0050);
        im[56] = it_w(6'h08, 0, 31, 16'h0108);
        im[57] = it_w(6'h17, 31, 0, 16'h0000);
        im[58] = it_w(6'h08, 0, 19, 16'h0077);
        im[60] = it_w(6'h08, 23, 23, 16'h0001);
        im[61] = it_w(6'h16, 31, 0, 16'h0000);
        im[64] = it_w(6'h08, 0, 24, 16'h0099);
        im[65] = it_w(6'h16, 31, 0, 16'h0000);
        im[66] = it_w(6'h2B, 20, 31, 16'h0054);
        im[67] = it_w(6'h2B, 20, 23, 16'h0058);
        im[68] = it_w(6'h2B, 20, 24, 16'h005C);
        im[69] = it_w(6'h2B, 20, 19, 16'h0060);
        im[70] = jt_w(6'h02, 70);
    end

    // main sequence
    initial begin
        m_pc = 32'd0;
        pc_tag = "R1";
        repeat (4) begin
            @(negedge clk);
            check("R1", "pc in reset", imem_addr, 32'd0);
            check("R1", "no store in reset", {31'd0, dmem_we}, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 120; c++) begin
            #1;
            compare_cycle();
            model_step();
            @(negedge clk);
        end
        for (int i = 0; i < 256; i++) begin
            check("R5", $sformatf("memory word %0d", i), dm[i], m_dm[i]);
        end
        done = 1'b1;
        finish_run();
    end

    // watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

endmodule